// File: doc/BRIEF.md
# Lockable Command Decoder with Status Response

This block is the command side of a framed converter interface. A serial front end, which is not part of this block, collects one 16-bit command word per frame. It pulses `frame_vld` in the cycle the frame completes. The decoder then acts on that command and registers the response word. That word is shifted out during the following frame, so every command is answered one frame later. In the meantime the response holds still.

The decoder keeps four pieces of state:
- a lock state,
- a standby bit,
- an opcode-fault bit,
- a small file of 8-bit registers.

While the block is locked it executes only the null command, unlock, and the single- and two-register reads. Every other opcode is refused. A refused opcode, or one that cannot be decoded, raises the fault bit in the status byte. That bit stays set until software reads the status byte.

A soft reset takes effect only when its frame completes. It restores all register defaults, re-enters the locked and standby states, and loads the ready word as the next response, exactly as a power-on reset does.

Top module: `lkcmd_core`

## Requirements
- R1: After `rst_n` the response is 0xFF04, the block is locked and in standby with the fault bit clear, and register a holds a XOR 0x5A (register 0 therefore reads 0x5A).
- R2: Null command 0x0000 answers {0x22, STAT}. STAT bit 0 is standby, bit 1 is the fault flag, and bits 7:2 are zero.
- R3: `rsp_word` changes only on a clock edge where `frame_vld` is high, and then reflects the command of that frame; `cmd_word` is ignored otherwise.
- R4: While locked, only 0x0000, unlock, RREG and RREGS execute. Reset, write, lock, standby and wakeup leave all state unchanged, set the fault flag, and answer {0x22, STAT}.
- R5: Any refused or undecodable command sets the fault flag, and its answer shows the flag set. A null command, or a register read that covers address 2, reports the flag and then clears it.
- R6: Unlock 0x0655 is always executed: it clears the lock and is echoed as the response.
- R7: Reset 0x0011 while unlocked, at the end of its frame, restores defaults, locks, sets standby, clears the fault flag, and answers 0xFF04.
- R8: While unlocked, lock 0x0555 locks, standby 0x0022 sets the standby bit and wakeup 0x0033 clears it. Each is echoed.
- R9: RREG 001a_aaaa_0000_0000 answers {001a_aaaa, reg[a]}. Address 2 reads STAT. An address of NREG or above is undecodable.
- R10: RREGS 001a_aaaa_nnnn_nnnn with n nonzero answers {reg[a], reg[a+1]}. It is undecodable when a+1 is NREG or above.
- R11: Write 010a_aaaa_dddd_dddd, while unlocked, stores d into register a and echoes the command. Addresses 0 to 2 and addresses of NREG or above are undecodable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| frame_vld | input | 1 | One-cycle pulse marking completion of a frame |
| cmd_word | input | 16 | Command word of the completed frame |
| rsp_word | output | 16 | Response returned during the next frame |

## Verification
The assertions take for granted that `rst_n` is asserted before the first edge. They also assume that `cmd_word` is settled whenever `frame_vld` is high; between frames it may hold any value. The bench raises `frame_vld` for a single cycle per frame and changes `cmd_word` only at the falling edge. During idle stretches it deliberately drives opcodes that would have an effect, such as reset, so that it can show these are not acted on.

// File: rtl/lkcmd_pkg.sv
package lkcmd_pkg;
  typedef enum logic [3:0] {
    K_NULL, K_RESET, K_STBY, K_WAKE, K_LOCK, K_UNLOCK,
    K_RREG, K_RREGS, K_WREG, K_BAD
  } op_kind_e;

  localparam logic [15:0] OP_NULL   = 16'h0000;
  localparam logic [15:0] OP_RESET  = 16'h0011;
  localparam logic [15:0] OP_STBY   = 16'h0022;
  localparam logic [15:0] OP_WAKE   = 16'h0033;
  localparam logic [15:0] OP_LOCK   = 16'h0555;
  localparam logic [15:0] OP_UNLOCK = 16'h0655;
  localparam logic [15:0] RSP_READY = 16'hFF04;
  localparam logic [7:0]  NULL_HDR  = 8'h22;
  localparam int STAT_ADDR  = 2;
  localparam int STBY_BIT   = 0;
  localparam int FAULT_BIT  = 1;

  function automatic logic [7:0] reg_default(input int unsigned a);
    return 8'(a) ^ 8'h5A;
  endfunction

  function automatic logic lock_exempt(input op_kind_e k);
    return (k == K_NULL) || (k == K_UNLOCK) || (k == K_RREG) || (k == K_RREGS);
  endfunction

  function automatic logic [7:0] stat_byte(input logic standby, input logic fault);
    logic [7:0] s;
    s = 8'h00;
    s[STBY_BIT]  = standby;
    s[FAULT_BIT] = fault;
    return s;
  endfunction
endpackage

// File: rtl/lkcmd_decode.sv
module lkcmd_decode
  import lkcmd_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int RO_REGS = 3
) (
  input  logic [15:0] cmd,
  input  logic        locked,
  output op_kind_e    kind,
  output logic [4:0]  addr,
  output logic [7:0]  data,
  output logic        permit
);
  localparam logic [5:0] NREG6 = 6'(NREG);
  localparam logic [5:0] RO6   = 6'(RO_REGS);

  logic [5:0] a6;
  assign addr = cmd[12:8];
  assign data = cmd[7:0];
  assign a6   = {1'b0, cmd[12:8]};

  always_comb begin
    kind = K_BAD;
    case (cmd)
      OP_NULL:   kind = K_NULL;
      OP_RESET:  kind = K_RESET;
      OP_STBY:   kind = K_STBY;
      OP_WAKE:   kind = K_WAKE;
      OP_LOCK:   kind = K_LOCK;
      OP_UNLOCK: kind = K_UNLOCK;
      default: begin
        if (cmd[15:13] == 3'b001) begin
          if (cmd[7:0] == 8'h00) kind = (a6 < NREG6) ? K_RREG : K_BAD;
          else                   kind = ((a6 + 6'd1) < NREG6) ? K_RREGS : K_BAD;
        end else if (cmd[15:13] == 3'b010) begin
          kind = (a6 >= RO6 && a6 < NREG6) ? K_WREG : K_BAD;
        end
      end
    endcase
  end

  assign permit = (kind != K_BAD) && (!locked || lock_exempt(kind));
endmodule

// File: rtl/lkcmd_regfile.sv
module lkcmd_regfile
  import lkcmd_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int RO_REGS = 3,
  localparam int AW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_a,
  output logic [7:0]    rdata_b
);
  logic [7:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    if (i < RO_REGS) begin : g_ro
      assign mem[i] = reg_default(i);
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               q <= reg_default(i);
        else if (clr)                             q <= reg_default(i);
        else if (we && waddr == AW'(i))           q <= wdata;
      end
      assign mem[i] = q;
    end
  end

  assign rdata_a = (int'(raddr_a) < NREG) ? mem[raddr_a] : 8'h00;
  assign rdata_b = (int'(raddr_b) < NREG) ? mem[raddr_b] : 8'h00;
endmodule

// File: rtl/lkcmd_core.sv
module lkcmd_core
  import lkcmd_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int RO_REGS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_vld,
  input  logic [15:0] cmd_word,
  output logic [15:0] rsp_word
);
  localparam int AW = $clog2(NREG);

  op_kind_e   kind;
  logic [4:0] addr, addr_b;
  logic [7:0] data, rf_a, rf_b, rd_a, rd_b, stat1;
  logic       permit, accept, reject, soft_rst, wr_en, stat_read;
  logic       locked, standby, fault;
  logic [15:0] rsp_q, rsp_next;

  lkcmd_decode #(.NREG(NREG), .RO_REGS(RO_REGS)) u_dec (
    .cmd(cmd_word), .locked(locked), .kind(kind),
    .addr(addr), .data(data), .permit(permit)
  );

  assign accept   = frame_vld && permit;
  assign reject   = frame_vld && !permit;
  assign soft_rst = accept && (kind == K_RESET);
  assign wr_en    = accept && (kind == K_WREG);
  assign addr_b   = addr + 5'd1;

  lkcmd_regfile #(.NREG(NREG), .RO_REGS(RO_REGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .we(wr_en),
    .waddr(addr[AW-1:0]), .wdata(data),
    .raddr_a(addr[AW-1:0]), .raddr_b(addr_b[AW-1:0]),
    .rdata_a(rf_a), .rdata_b(rf_b)
  );

  assign stat1 = stat_byte(standby, fault);
  assign rd_a  = (addr   == 5'(STAT_ADDR)) ? stat1 : rf_a;
  assign rd_b  = (addr_b == 5'(STAT_ADDR)) ? stat1 : rf_b;

  assign stat_read = accept && ((kind == K_NULL) ||
                     (kind == K_RREG  && addr == 5'(STAT_ADDR)) ||
                     (kind == K_RREGS && (addr == 5'(STAT_ADDR) || addr_b == 5'(STAT_ADDR))));

  always_comb begin
    if (!permit) rsp_next = {NULL_HDR, stat_byte(standby, 1'b1)};
    else begin
      case (kind)
        K_NULL:  rsp_next = {NULL_HDR, stat1};
        K_RESET: rsp_next = RSP_READY;
        K_RREG:  rsp_next = {3'b001, addr, rd_a};
        K_RREGS: rsp_next = {rd_a, rd_b};
        default: rsp_next = cmd_word;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked  <= 1'b1;
      standby <= 1'b1;
      fault   <= 1'b0;
      rsp_q   <= RSP_READY;
    end else if (frame_vld) begin
      rsp_q <= rsp_next;
      if (soft_rst) begin
        locked  <= 1'b1;
        standby <= 1'b1;
        fault   <= 1'b0;
      end else begin
        if (reject)         fault <= 1'b1;
        else if (stat_read) fault <= 1'b0;
        if (accept && kind == K_UNLOCK) locked  <= 1'b0;
        if (accept && kind == K_LOCK)   locked  <= 1'b1;
        if (accept && kind == K_STBY)   standby <= 1'b1;
        if (accept && kind == K_WAKE)   standby <= 1'b0;
      end
    end
  end

  assign rsp_word = rsp_q;

  assert_ready_after_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rsp_word == RSP_READY && locked && standby && !fault));

  assert_locked_write_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && locked && kind == K_WREG) |=> (rsp_word[15:8] == NULL_HDR && fault));

  assert_rsp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> $stable(rsp_word));

  assert_unlock_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && kind == K_UNLOCK) |=> (!locked && rsp_word == OP_UNLOCK));

  assert_fault_on_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && kind == K_BAD) |=> fault);
endmodule

// File: tb/tb_lkcmd_core.sv
module tb_lkcmd_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_vld = 1'b0;
  logic [15:0] cmd_word = 16'h0000;
  logic [15:0] rsp_word;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lkcmd_core dut (.clk(clk), .rst_n(rst_n), .frame_vld(frame_vld),
                  .cmd_word(cmd_word), .rsp_word(rsp_word));

  function automatic logic [7:0] dflt(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] c, input logic [15:0] exp, input string req);
    @(negedge clk);
    cmd_word  = c;
    frame_vld = 1'b1;
    @(negedge clk);
    frame_vld = 1'b0;
    cmd_word  = 16'hA5A5;
    check(rsp_word, exp, req);
  endtask

  task automatic t_power_on;
    check(rsp_word, 16'hFF04, "R1 ready after power-on");
    send(16'h0000, 16'h2201, "R2 null in standby");
    send(16'h2500, {8'h25, dflt(5)}, "R1 R9 default reg5");
    send(16'h2000, {8'h20, dflt(0)}, "R9 reg0");
  endtask

  task automatic t_locked_filter;
    send(16'h45AA, 16'h2203, "R4 write refused");
    send(16'h2500, {8'h25, dflt(5)}, "R4 reg5 unchanged");
    send(16'h0033, 16'h2203, "R4 wakeup refused");
    send(16'h0011, 16'h2203, "R4 reset refused");
    send(16'h0555, 16'h2203, "R4 lock refused");
    send(16'h0000, 16'h2203, "R5 null reports fault");
    send(16'h0000, 16'h2201, "R5 fault cleared, R4 standby kept");
  endtask

  task automatic t_unlock_write;
    send(16'h0655, 16'h0655, "R6 unlock echo");
    send(16'h45AA, 16'h45AA, "R11 write echo");
    send(16'h2500, 16'h25AA, "R11 readback");
    send(16'h0033, 16'h0033, "R8 wakeup echo");
    send(16'h0000, 16'h2200, "R8 standby cleared");
    send(16'h0022, 16'h0022, "R8 standby echo");
    send(16'h0000, 16'h2201, "R8 standby set");
    send(16'h0033, 16'h0033, "R8 wakeup again");
  endtask

  task automatic t_multi_read;
    send(16'h2401, {dflt(4), 8'hAA}, "R10 pair read");
    send(16'h7777, 16'h2202, "R5 undecodable");
    send(16'h2101, {dflt(1), 8'h02}, "R10 R5 pair covers STAT");
    send(16'h0000, 16'h2200, "R5 cleared by pair read");
  endtask

  task automatic t_bad_addr;
    send(16'h4112, 16'h2202, "R11 read-only address");
    send(16'h0000, 16'h2202, "R5 report");
    send(16'h3400, 16'h2202, "R9 address out of range");
    send(16'h0000, 16'h2202, "R5 report");
    send(16'h2F01, 16'h2202, "R10 pair past end");
    send(16'h0000, 16'h2202, "R5 report");
    send(16'h0000, 16'h2200, "R5 clear");
  endtask

  task automatic t_hold;
    send(16'h2500, 16'h25AA, "R3 response");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      cmd_word = (i % 2 == 0) ? 16'h0011 : 16'h0555;
    end
    check(rsp_word, 16'h25AA, "R3 hold between frames");
    send(16'h0000, 16'h2200, "R3 idle command not acted");
  endtask

  task automatic t_lock_cmd;
    send(16'h0555, 16'h0555, "R8 lock echo");
    send(16'h45BB, 16'h2202, "R8 lock effective");
    send(16'h0000, 16'h2202, "R5 report");
    send(16'h0655, 16'h0655, "R6 unlock again");
  endtask

  task automatic t_soft_reset;
    send(16'h0011, 16'hFF04, "R7 ready word");
    send(16'h2500, {8'h25, dflt(5)}, "R7 defaults restored");
    send(16'h0000, 16'h2201, "R7 standby set fault clear");
    send(16'h45CC, 16'h2203, "R7 relocked");
    send(16'h0000, 16'h2203, "R5 report");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_power_on();
    t_locked_filter();
    t_unlock_write();
    t_multi_read();
    t_bad_addr();
    t_hold();
    t_lock_cmd();
    t_soft_reset();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule